// File: doc/BRIEF.md
# Sample Fetch DMA Sequencer

This block paces a sample-playback channel that pulls its data bytes out of memory by borrowing bus cycles. Software programs a mode/rate register, a start-address register, a length register and an enable register through a small write port. Once enabled, a 12-bit rate timer counts CPU clocks. Each time it expires, the block raises a one-cycle fetch request with a 16-bit address. It waits for the memory's data-valid strobe and hands the returned byte to the downstream output unit. After that it advances its address pointer and remaining-length counter.

The start address and the length are scaled from the register contents. The address pointer stays in the upper half of the address space. At the end of a sample the channel stops, loops, or stops and raises an interrupt, depending on two mode bits. A status byte reports the interrupt flag and whether the channel is playing.

Top module: `smp_fetch_seq`

## Requirements
- R1: The mode field is bits 7:6 of a write with `wr_sel`=0. Value 00 plays once with no interrupt. Any value with bit 6 set loops and never interrupts. Value 10 plays once and then sets the interrupt flag.
- R2: The rate field is bits 3:0 of the mode write. It selects a fetch period in clocks, for index 0 to 15: 0xD60, 0xBE0, 0xAA0, 0xA00, 0x8F0, 0x7F0, 0x710, 0x6B0, 0x5F0, 0x500, 0x470, 0x400, 0x350, 0x2A0, 0x240, 0x1B0. Successive fetch requests are exactly one period apart. The first request comes period−1 cycles after the clock edge that captures the enabling write.
- R3: A write with `wr_sel`=1 sets the start address to 0xC000 + value×64. Each completed fetch moves the address up by one, and 0xFFFF is followed by 0x8000.
- R4: A write with `wr_sel`=2 sets the length. One pass of a sample fetches value×16+1 bytes.
- R5: In loop mode, the fetch after the last byte of a pass restarts at the start address with the full length. The channel stays active.
- R6: Bit 4 of a write with `wr_sel`=3 enables the channel. Enabling from idle reloads the address, length and rate timer. Writing 1 while the channel is active changes nothing. Writing 0 stops the channel at once, and no further requests are issued.
- R7: `status_o` carries the interrupt flag in bit 7 and the active flag in bit 4, with all other bits 0. Reading it clears nothing.
- R8: The interrupt flag is cleared by any write with `wr_sel`=3, or by a mode write whose bit 7 is 0. A mode write with bit 7 set leaves the flag unchanged.
- R9: Reset clears the interrupt and active flags. The mode, rate, address and length registers keep their values.
- R10: `fetch_req_o` is high for one cycle with the address on `fetch_addr_o`. The byte on `fetch_data_i` is presented on `byte_o`, with `byte_valid_o` high, in the cycle after `fetch_valid_i`. A `fetch_valid_i` with no fetch outstanding is ignored.
- R11: When a one-shot sample ends, the active flag clears on the same edge at which the interrupt flag sets. If that edge also carries an acknowledging write, the new interrupt wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rst_n | input | 1 | Active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 mode/rate, 1 address, 2 length, 3 enable |
| wr_data | input | 8 | Register write data |
| status_o | output | 8 | Status byte (bit 7 interrupt, bit 4 active) |
| irq_o | output | 1 | Interrupt request |
| fetch_req_o | output | 1 | One-cycle memory fetch request |
| fetch_addr_o | output | 16 | Fetch address |
| fetch_valid_i | input | 1 | Memory data-valid strobe |
| fetch_data_i | input | 8 | Memory read data |
| byte_valid_o | output | 1 | Fetched byte valid toward the output unit |
| byte_o | output | 8 | Fetched byte |

## Verification
The final byte of a one-shot sample can return on the same edge as a software write to the enable register. That edge then sets the end-of-sample interrupt, and the acknowledge from the write would clear it. The bench holds the memory answer back and drives `fetch_valid_i` and an enable write of 0 in the same cycle. It then expects the byte to be delivered, the channel to be idle and the interrupt flag to be set. A further enable write is expected to clear the flag.

// File: rtl/smp_fetch_pkg.sv
package smp_fetch_pkg;

  localparam int RATE_W = 4;
  localparam int TMR_W  = 12;
  localparam int LEN_W  = 12;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 8;

  typedef enum logic [1:0] {
    SEL_MODE = 2'd0,
    SEL_ADDR = 2'd1,
    SEL_LEN  = 2'd2,
    SEL_CTRL = 2'd3
  } reg_sel_e;

  // fetch period in clocks for each rate index
  function automatic logic [TMR_W-1:0] period_of(input logic [RATE_W-1:0] idx);
    logic [TMR_W-1:0] p;
    case (idx)
      4'd0:  p = 12'hD60;
      4'd1:  p = 12'hBE0;
      4'd2:  p = 12'hAA0;
      4'd3:  p = 12'hA00;
      4'd4:  p = 12'h8F0;
      4'd5:  p = 12'h7F0;
      4'd6:  p = 12'h710;
      4'd7:  p = 12'h6B0;
      4'd8:  p = 12'h5F0;
      4'd9:  p = 12'h500;
      4'd10: p = 12'h470;
      4'd11: p = 12'h400;
      4'd12: p = 12'h350;
      4'd13: p = 12'h2A0;
      4'd14: p = 12'h240;
      default: p = 12'h1B0;
    endcase
    return p;
  endfunction

  function automatic logic [ADDR_W-1:0] start_of(input logic [7:0] v);
    return 16'hC000 + {2'b00, v, 6'b000000};
  endfunction

  function automatic logic [LEN_W-1:0] len_of(input logic [7:0] v);
    return {v, 4'h0};
  endfunction

  // increment keeping the top address bit set
  function automatic logic [ADDR_W-1:0] step_addr(input logic [ADDR_W-1:0] a);
    return {1'b1, a[ADDR_W-2:0] + {{(ADDR_W-2){1'b0}}, 1'b1}};
  endfunction

endpackage

// File: rtl/smp_rate_timer.sv
module smp_rate_timer #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             run,
  input  logic [CNT_W-1:0] period,
  output logic             tick
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] reload;

  assign reload = period - {{(CNT_W-1){1'b0}}, 1'b1};
  assign tick   = run && !restart && (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (restart) begin
      cnt_q <= reload;
    end else if (run) begin
      if (cnt_q == '0) cnt_q <= reload;
      else             cnt_q <= cnt_q - {{(CNT_W-1){1'b0}}, 1'b1};
    end
  end
endmodule

// File: rtl/smp_pointer.sv
module smp_pointer
  import smp_fetch_pkg::*;
#(
  parameter int A_W = ADDR_W,
  parameter int L_W = LEN_W
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic           advance,
  input  logic [A_W-1:0] start_addr,
  input  logic [L_W-1:0] start_len,
  output logic [A_W-1:0] addr,
  output logic           len_zero
);
  logic [L_W-1:0] left_q;

  assign len_zero = (left_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr   <= '0;
      left_q <= '0;
    end else if (load || (advance && len_zero)) begin
      addr   <= start_addr;
      left_q <= start_len;
    end else if (advance) begin
      addr   <= step_addr(addr);
      left_q <= left_q - {{(L_W-1){1'b0}}, 1'b1};
    end
  end
endmodule

// File: rtl/smp_fetch_seq.sv
module smp_fetch_seq
  import smp_fetch_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int AW = ADDR_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [1:0]    wr_sel,
  input  logic [7:0]    wr_data,
  output logic [7:0]    status_o,
  output logic          irq_o,
  output logic          fetch_req_o,
  output logic [AW-1:0] fetch_addr_o,
  input  logic          fetch_valid_i,
  input  logic [DW-1:0] fetch_data_i,
  output logic          byte_valid_o,
  output logic [DW-1:0] byte_o
);
  // software registers: not reset, they keep their contents
  logic [1:0]        mode_q;
  logic [RATE_W-1:0] rate_q;
  logic [7:0]        areg_q;
  logic [7:0]        lreg_q;

  logic active_q, irq_q, wait_q, bvalid_q;
  logic [DW-1:0] bdata_q;

  // named events
  logic wr_mode, wr_addr, wr_len, wr_ctrl;
  logic start_evt, stop_evt, ack_evt;
  logic tick, fetch_go, done_evt, end_evt, irq_set, len_zero;
  logic [AW-1:0] ptr_addr;

  assign wr_mode = wr_en && (wr_sel == SEL_MODE);
  assign wr_addr = wr_en && (wr_sel == SEL_ADDR);
  assign wr_len  = wr_en && (wr_sel == SEL_LEN);
  assign wr_ctrl = wr_en && (wr_sel == SEL_CTRL);

  assign start_evt = wr_ctrl && wr_data[4] && !active_q;
  assign stop_evt  = wr_ctrl && !wr_data[4];
  assign ack_evt   = wr_ctrl || (wr_mode && !wr_data[7]);

  assign fetch_go  = tick && !wait_q;
  assign done_evt  = active_q && wait_q && fetch_valid_i;
  assign end_evt   = done_evt && len_zero && !mode_q[0];
  assign irq_set   = end_evt && (mode_q == 2'b10);

  always_ff @(posedge clk) begin
    if (wr_mode) begin
      mode_q <= wr_data[7:6];
      rate_q <= wr_data[RATE_W-1:0];
    end
    if (wr_addr) areg_q <= wr_data;
    if (wr_len)  lreg_q <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      irq_q    <= 1'b0;
      wait_q   <= 1'b0;
      bvalid_q <= 1'b0;
      bdata_q  <= '0;
    end else begin
      if (stop_evt)       active_q <= 1'b0;
      else if (start_evt) active_q <= 1'b1;
      else if (end_evt)   active_q <= 1'b0;

      if (irq_set)      irq_q <= 1'b1;
      else if (ack_evt) irq_q <= 1'b0;

      if (stop_evt || start_evt) wait_q <= 1'b0;
      else if (fetch_go)         wait_q <= 1'b1;
      else if (done_evt)         wait_q <= 1'b0;

      bvalid_q <= done_evt;
      if (done_evt) bdata_q <= fetch_data_i;
    end
  end

  smp_rate_timer #(.CNT_W(TMR_W)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (start_evt),
    .run     (active_q),
    .period  (period_of(rate_q)),
    .tick    (tick)
  );

  smp_pointer #(.A_W(AW), .L_W(LEN_W)) u_ptr (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (start_evt),
    .advance    (done_evt),
    .start_addr (start_of(areg_q)),
    .start_len  (len_of(lreg_q)),
    .addr       (ptr_addr),
    .len_zero   (len_zero)
  );

  assign fetch_req_o  = fetch_go;
  assign fetch_addr_o = ptr_addr;
  assign byte_valid_o = bvalid_q;
  assign byte_o       = bdata_q;
  assign irq_o        = irq_q;
  assign status_o     = {irq_q, 2'b00, active_q, 4'b0000};
endmodule

// File: rtl/smp_fetch_chk.sv
module smp_fetch_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic [1:0]  wr_sel,
  input logic [7:0]  wr_data,
  input logic        fetch_req_o,
  input logic [15:0] fetch_addr_o,
  input logic        fetch_valid_i,
  input logic        byte_valid_o,
  input logic        active,
  input logic        irq,
  input logic [1:0]  mode
);
  logic ack_wr, stop_wr;
  assign ack_wr  = wr_en && ((wr_sel == 2'd3) || ((wr_sel == 2'd0) && !wr_data[7]));
  assign stop_wr = wr_en && (wr_sel == 2'd3) && !wr_data[4];

  AST_IRQ_MODE_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(mode) == 2'b10); // R1
  AST_ADDR_HIGH_HALF: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_req_o |-> fetch_addr_o[15]); // R3
  AST_LOOP_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    (active && mode[0] && !stop_wr) |=> active); // R5
  AST_REQ_NEEDS_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_req_o |-> active); // R6
  AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !ack_wr) |=> irq); // R7
  AST_REQ_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_req_o |=> !fetch_req_o); // R10
  AST_BYTE_FOLLOWS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    byte_valid_o |-> $past(fetch_valid_i)); // R10
  AST_IRQ_WITH_END: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $fell(active)); // R11
endmodule

bind smp_fetch_seq smp_fetch_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .wr_en         (wr_en),
  .wr_sel        (wr_sel),
  .wr_data       (wr_data),
  .fetch_req_o   (fetch_req_o),
  .fetch_addr_o  (fetch_addr_o),
  .fetch_valid_i (fetch_valid_i),
  .byte_valid_o  (byte_valid_o),
  .active        (active_q),
  .irq           (irq_q),
  .mode          (mode_q)
);

// File: tb/smp_fetch_seq_tb.sv
module smp_fetch_seq_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = 2'd0;
  logic [7:0]  wr_data = 8'd0;
  logic [7:0]  status_o;
  logic        irq_o;
  logic        fetch_req_o;
  logic [15:0] fetch_addr_o;
  logic        fetch_valid_i;
  logic [7:0]  fetch_data_i;
  logic        byte_valid_o;
  logic [7:0]  byte_o;

  always #4 clk = ~clk;

  smp_fetch_seq u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .status_o(status_o), .irq_o(irq_o), .fetch_req_o(fetch_req_o),
    .fetch_addr_o(fetch_addr_o), .fetch_valid_i(fetch_valid_i),
    .fetch_data_i(fetch_data_i), .byte_valid_o(byte_valid_o), .byte_o(byte_o)
  );

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string rq, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  // memory model: answers two cycles after a request, data = addr lo ^ addr hi
  bit          mem_auto = 1'b1;
  logic        p1 = 0, p2 = 0, mem_valid = 0;
  logic [15:0] a1, a2, a3;
  logic        man_valid = 1'b0;
  logic [7:0]  man_data = 8'h00;

  function automatic logic [7:0] mdata(input logic [15:0] a);
    return a[7:0] ^ a[15:8];
  endfunction

  always @(negedge clk) begin
    mem_valid = p2; a3 = a2;
    p2 = p1;        a2 = a1;
    p1 = fetch_req_o && mem_auto; a1 = fetch_addr_o;
  end
  assign fetch_valid_i = mem_valid | man_valid;
  assign fetch_data_i  = mem_valid ? mdata(a3) : man_data;

  // cycle counter and request monitor
  longint cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  bit          mon_on = 1'b0;
  int          req_cnt = 0;
  longint      last_req_cyc = 0;
  logic [15:0] exp_addr, exp_start;
  int          exp_left, exp_len, exp_per;
  logic [7:0]  last_data = 8'h00;

  always @(negedge clk) begin
    if (mon_on && fetch_req_o) begin
      chk(fetch_addr_o == exp_addr, "R3 fetch address", fetch_addr_o, exp_addr);
      chk((cyc - last_req_cyc) == exp_per, "R2 fetch spacing", cyc - last_req_cyc, exp_per);
      req_cnt++;
      last_req_cyc = cyc;
      last_data = mdata(fetch_addr_o);
      if (exp_left == 0) begin
        exp_addr = exp_start;
        exp_left = exp_len;
      end else begin
        exp_addr = (exp_addr == 16'hFFFF) ? 16'h8000 : exp_addr + 16'd1;
        exp_left--;
      end
    end
    if (mon_on && byte_valid_o)
      chk(byte_o == last_data, "R10 byte handed on", byte_o, last_data);
  end

  task automatic wr(input logic [1:0] sel, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic start_run(input logic [7:0] md, input logic [7:0] av, input logic [7:0] lv,
                           input logic [15:0] st, input int per);
    wr(2'd0, md); wr(2'd1, av); wr(2'd2, lv);
    exp_start = st; exp_addr = st; exp_len = lv * 16; exp_left = exp_len; exp_per = per;
    req_cnt = 0; mon_on = 1'b1;
    wr(2'd3, 8'h10);
    last_req_cyc = cyc - 1;
  endtask

  task automatic wait_idle(input int tmo);
    for (int i = 0; i < tmo; i++) begin
      @(negedge clk);
      if (status_o[4] == 1'b0) break;
    end
  endtask

  task automatic wait_reqs(input int n, input int tmo);
    for (int i = 0; i < tmo; i++) begin
      @(negedge clk);
      if (req_cnt >= n) break;
    end
  endtask

  typedef struct packed {
    logic [7:0]  md;
    logic [7:0]  av;
    logic [7:0]  lv;
    logic [15:0] st;
    logic [11:0] per;
    logic [15:0] nb;
    logic        irq;
  } vec_t;

  localparam vec_t VECS [4] = '{
    '{8'h0F, 8'h00, 8'h00, 16'hC000, 12'h1B0, 16'd1,  1'b0},
    '{8'h8E, 8'hFF, 8'h04, 16'hFFC0, 12'h240, 16'd65, 1'b1},
    '{8'h80, 8'h01, 8'h00, 16'hC040, 12'hD60, 16'd1,  1'b1},
    '{8'h07, 8'h10, 8'h01, 16'hC400, 12'h6B0, 16'd17, 1'b0}
  };

  initial begin
    #(8 * 190000);
    chk(1'b0, "watchdog", 0, 1);
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(status_o == 8'h00, "R9 reset status", status_o, 8'h00);
    chk(irq_o == 1'b0, "R9 reset irq", irq_o, 0);
    chk(fetch_req_o == 1'b0, "R9 reset no request", fetch_req_o, 0);

    // table walk: one-shot runs, spacing, address wrap, length, irq mode
    for (int v = 0; v < 4; v++) begin
      start_run(VECS[v].md, VECS[v].av, VECS[v].lv, VECS[v].st, int'(VECS[v].per));
      chk(irq_o == 1'b0, "R8 enable write clears irq", irq_o, 0);
      chk(status_o[4] == 1'b1, "R6 channel active", status_o[4], 1);
      wait_idle(int'(VECS[v].nb) * int'(VECS[v].per) + 4096);
      repeat (3) @(negedge clk);
      chk(req_cnt == int'(VECS[v].nb), "R4 bytes per pass", req_cnt, VECS[v].nb);
      chk(irq_o == VECS[v].irq, "R1 irq by mode", irq_o, VECS[v].irq);
      chk(status_o == {VECS[v].irq, 7'b0}, "R7 status layout", status_o, {VECS[v].irq, 7'b0});
    end

    // interrupt acknowledge paths, status reads
    start_run(8'h8F, 8'h05, 8'h00, 16'hC140, 12'h1B0);
    wait_idle(4096);
    repeat (3) @(negedge clk);
    chk(irq_o == 1'b1, "R1 one-shot irq", irq_o, 1);
    repeat (2) @(negedge clk);
    chk(status_o == 8'h80, "R7 read leaves irq", status_o, 8'h80);
    wr(2'd0, 8'h8F);
    chk(irq_o == 1'b1, "R8 mode bit7=1 keeps irq", irq_o, 1);
    wr(2'd0, 8'h0F);
    chk(irq_o == 1'b0, "R8 mode bit7=0 clears irq", irq_o, 0);

    // reset retention: set irq, reset, re-enable without reprogramming
    wr(2'd0, 8'h8F);
    start_run(8'h8F, 8'h05, 8'h00, 16'hC140, 12'h1B0);
    wait_idle(4096);
    repeat (3) @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(status_o == 8'h00, "R9 reset clears flags", status_o, 8'h00);
    exp_addr = 16'hC140; exp_left = 0; exp_len = 0; req_cnt = 0;
    wr(2'd3, 8'h10);
    last_req_cyc = cyc - 1;
    wait_idle(4096);
    repeat (3) @(negedge clk);
    chk(req_cnt == 1, "R9 registers retained (length)", req_cnt, 1);
    chk(irq_o == 1'b1, "R9 registers retained (mode)", irq_o, 1);

    // loop mode (11), re-enable while active, then stop
    start_run(8'hCF, 8'h02, 8'h01, 16'hC080, 12'h1B0);
    wait_reqs(5, 8000);
    wr(2'd3, 8'h10);
    wait_reqs(20, 16000);
    chk(req_cnt == 20, "R5 loop keeps fetching", req_cnt, 20);
    chk(status_o == 8'h10, "R5 loop active no irq", status_o, 8'h10);
    wr(2'd3, 8'h00);
    chk(status_o[4] == 1'b0, "R6 disable stops", status_o[4], 0);
    begin
      int held;
      held = req_cnt;
      repeat (1000) @(negedge clk);
      chk(req_cnt == held, "R6 no requests after stop", req_cnt, held);
      chk(byte_valid_o == 1'b0, "R6 no byte after stop", byte_valid_o, 0);
    end

    // R11: last byte returns in the same cycle as an acknowledging write
    mem_auto = 1'b0;
    start_run(8'h8F, 8'h00, 8'h00, 16'hC000, 12'h1B0);
    wait_reqs(1, 4096);
    @(negedge clk);
    man_valid = 1'b1; man_data = 8'hC0;
    wr_en = 1'b1; wr_sel = 2'd3; wr_data = 8'h00;
    @(negedge clk);
    man_valid = 1'b0; wr_en = 1'b0;
    chk(irq_o == 1'b1, "R11 irq set wins over ack", irq_o, 1);
    chk(status_o[4] == 1'b0, "R11 active cleared", status_o[4], 0);
    chk(byte_valid_o == 1'b1 && byte_o == 8'hC0, "R10 byte delivered", byte_o, 8'hC0);
    wr(2'd3, 8'h00);
    chk(irq_o == 1'b0, "R8 later enable write clears irq", irq_o, 0);

    // R10: stray data-valid while idle is ignored
    mon_on = 1'b0;
    @(negedge clk);
    man_valid = 1'b1; man_data = 8'h5A;
    @(negedge clk);
    man_valid = 1'b0;
    chk(byte_valid_o == 1'b0, "R10 stray valid ignored", byte_valid_o, 0);
    mem_auto = 1'b1;

    repeat (4) @(negedge clk);
    summary();
  end
endmodule